// File: doc/BRIEF.md
# Two-Speed Serial Radix-4 Booth Multiplier

This block multiplies two signed two's complement operands of `W` bits and returns their full `2W`-bit product. It works serially, retiring one radix-4 Booth digit of the multiplier per step. The multiplier operand lives in the low section of a single shift register, and the accumulator occupies the high section. The next digit is always read from the bottom three bits of that register.

The block runs at two speeds. A digit that recodes to zero (`000` or `111`) is retired in one clock, and only the register shift and the digit count advance. A nonzero digit holds the register for `SLOW_CYC` clocks before the sum is latched. This gives the partial-product selector and the adder time to settle on a slower path. The time taken therefore depends on how many nonzero digits the multiplier operand has.

To use the block, pulse `start` with both operands while the block is idle. Then wait for the one-cycle `done` pulse and read `product`.

Top module: `tsm_mult`

## Requirements
- R1: When `done` is high, `product` equals the signed product of the `x` and `y` values that were captured at the accepted start, taken as a `2W`-bit two's complement value.
- R2: Each digit is recoded from the triple (bit 2i+1, bit 2i, bit 2i−1) of `y`, with an implicit 0 below bit 0. The patterns 000 and 111 select 0. The patterns 001 and 010 select +x, 011 selects +2x, 100 selects −2x, and 101 and 110 select −x.
- R3: A digit whose triple is 000 or 111 takes exactly one clock.
- R4: A digit with a nonzero recoding takes exactly `SLOW_CYC` clocks.
- R5: The block processes N = floor((W+2)/2) digits, with `y` sign-extended to 2N bits. `busy` stays high for exactly (N−O) + O·SLOW_CYC clocks, where O is the number of nonzero digits. With y = 0 this is N clocks.
- R6: `start` is accepted only while `busy` is low. `busy` rises on the clock that accepts it. `done` is high for exactly one clock, on the clock where `busy` falls, and `busy` is low whenever `done` is high.
- R7: A `start` raised while `busy` is high is ignored. The running operation keeps its operands, and no additional result is produced.
- R8: After `done`, `product` holds its value until the next accepted `start`.
- R9: After a synchronous reset (`rst` high at a clock edge), `busy`, `done` and `product` are all 0.
- R10: Extreme operands produce exact products without overflow. This covers the most negative value, the most positive value and −1, in every combination of sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a multiplication; accepted when idle |
| x | input | W | Multiplicand, signed |
| y | input | W | Multiplier, signed |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2W | Signed product |

## Verification
The multiplier operand is chosen both to give correct products and to steer the digit mix.

- y = 0 gives the all-skip minimum latency.
- y = −1 gives a single nonzero digit at position 0.
- The alternating patterns make every digit that carries a bit of `y` nonzero.
- Small values such as 1, 2, 3 and −2 place each recoding class of R2 in a known digit.

Extreme operands check that the accumulator does not overflow. Random pairs check products and the latency formula over mixed digit patterns. A mid-operation `start` with different operands checks that the running result and the result count are left unchanged.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

    typedef enum logic [2:0] {
        BD_ZERO,
        BD_POS1,
        BD_POS2,
        BD_NEG2,
        BD_NEG1
    } booth_op_e;

    typedef struct packed {
        logic load;
        logic commit;
    } tsm_step_t;

    function automatic int digit_count(input int w);
        return (w + 2) / 2;
    endfunction

    function automatic booth_op_e booth_decode(input logic [2:0] t);
        booth_op_e op;
        unique case (t)
            3'b000, 3'b111: op = BD_ZERO;
            3'b001, 3'b010: op = BD_POS1;
            3'b011:         op = BD_POS2;
            3'b100:         op = BD_NEG2;
            default:        op = BD_NEG1;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/tsm_booth_sel.sv
module tsm_booth_sel
    import tsm_pkg::*;
#(
    parameter int W = 16,
    localparam int A = W + 2
) (
    input  logic [2:0]          triple,
    input  logic [W-1:0]        mcand,
    output logic signed [A-1:0] pp,
    output logic                is_zero
);
    booth_op_e        op;
    logic [A-1:0]     mag;
    logic             neg;

    always_comb begin
        op  = booth_decode(triple);
        neg = (op == BD_NEG1) || (op == BD_NEG2);
        unique case (op)
            BD_POS1, BD_NEG1: mag = {{2{mcand[W-1]}}, mcand};
            BD_POS2, BD_NEG2: mag = {mcand[W-1], mcand, 1'b0};
            default:          mag = '0;
        endcase
        pp      = neg ? $signed(~mag + 1'b1) : $signed(mag);
        is_zero = (op == BD_ZERO);
    end
endmodule

// File: rtl/tsm_datapath.sv
module tsm_datapath
    import tsm_pkg::*;
#(
    parameter int W = 16,
    localparam int N = digit_count(W),
    localparam int L = 2 * N,
    localparam int A = W + 2
) (
    input  logic           clk,
    input  logic           rst,
    input  tsm_step_t      step,
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic           digit_zero,
    output logic [W-1:0]   mcand_q,
    output logic [2*W-1:0] product
);
    logic signed [A-1:0] acc_q;
    logic [L-1:0]        low_q;
    logic                prev_q;
    logic signed [A-1:0] pp;
    logic signed [A-1:0] sum;

    tsm_booth_sel #(.W(W)) u_sel (
        .triple  ({low_q[1:0], prev_q}),
        .mcand   (mcand_q),
        .pp      (pp),
        .is_zero (digit_zero)
    );

    assign sum = acc_q + pp;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            low_q   <= '0;
            prev_q  <= 1'b0;
            mcand_q <= '0;
        end else if (step.load) begin
            acc_q   <= '0;
            low_q   <= {{(L-W){y[W-1]}}, y};
            prev_q  <= 1'b0;
            mcand_q <= x;
        end else if (step.commit) begin
            acc_q   <= sum >>> 2;
            low_q   <= {sum[1:0], low_q[L-1:2]};
            prev_q  <= low_q[1];
        end
    end

    assign product = {acc_q[2*W-L-1:0], low_q};
endmodule

// File: rtl/tsm_ctrl.sv
module tsm_ctrl
    import tsm_pkg::*;
#(
    parameter int W        = 16,
    parameter int SLOW_CYC = 2,
    localparam int N  = digit_count(W),
    localparam int DW = (N > 1) ? $clog2(N) : 1,
    localparam int KW = $clog2(SLOW_CYC + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      digit_zero,
    output tsm_step_t step,
    output logic      busy,
    output logic      done
);
    logic [DW-1:0] dig_q;
    logic [KW-1:0] wait_q;
    logic          settled;

    assign settled     = (wait_q == KW'(SLOW_CYC - 1));
    assign step.load   = start && !busy;
    assign step.commit = busy && (digit_zero || settled);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            dig_q  <= '0;
            wait_q <= '0;
        end else begin
            done <= 1'b0;
            if (step.load) begin
                busy   <= 1'b1;
                dig_q  <= '0;
                wait_q <= '0;
            end else if (busy) begin
                if (step.commit) begin
                    wait_q <= '0;
                    if (dig_q == DW'(N - 1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        dig_q <= dig_q + 1'b1;
                    end
                end else begin
                    wait_q <= wait_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tsm_mult.sv
module tsm_mult
    import tsm_pkg::*;
#(
    parameter int W        = 16,
    parameter int SLOW_CYC = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] product
);
    tsm_step_t      step;
    logic           digit_zero;
    logic [W-1:0]   mcand_q;
    logic           commit;

    assign commit = step.commit;

    tsm_ctrl #(.W(W), .SLOW_CYC(SLOW_CYC)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .digit_zero (digit_zero),
        .step       (step),
        .busy       (busy),
        .done       (done)
    );

    tsm_datapath #(.W(W)) u_dp (
        .clk        (clk),
        .rst        (rst),
        .step       (step),
        .x          (x),
        .y          (y),
        .digit_zero (digit_zero),
        .mcand_q    (mcand_q),
        .product    (product)
    );
endmodule

// File: rtl/tsm_mult_chk.sv
module tsm_mult_chk #(
    parameter int W        = 16,
    parameter int SLOW_CYC = 2
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic           digit_zero,
    input logic           commit,
    input logic [W-1:0]   mcand_q,
    input logic [2*W-1:0] product
);
    localparam int N = (W + 2) / 2;
    int lat_cnt;

    always_ff @(posedge clk) begin
        if (rst || (start && !busy)) lat_cnt <= 0;
        else if (busy)               lat_cnt <= lat_cnt + 1;
    end

    p_done_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_not_busy_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_start_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(mcand_q));

    p_zero_digit_fast_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && digit_zero) |-> commit);

    p_product_held_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(product));

    p_latency_bound_r5: assert property (@(posedge clk) disable iff (rst)
        busy |-> (lat_cnt < N * SLOW_CYC));
endmodule

bind tsm_mult tsm_mult_chk #(.W(W), .SLOW_CYC(SLOW_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .digit_zero (digit_zero),
    .commit     (commit),
    .mcand_q    (mcand_q),
    .product    (product)
);

// File: tb/tb_tsm_mult.sv
module tb_tsm_mult;
    localparam int W        = 16;
    localparam int SLOW_CYC = 2;
    localparam int N        = (W + 2) / 2;
    localparam int CLK_PER  = 10;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [W-1:0]   x_i = '0;
    logic [W-1:0]   y_i = '0;
    logic           busy;
    logic           done;
    logic [2*W-1:0] product;

    int checks = 0;
    int fails  = 0;
    int lat    = 0;

    typedef struct {
        logic [2*W-1:0] prod;
        int             lat;
        string          tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PER/2) clk = ~clk;

    tsm_mult #(.W(W), .SLOW_CYC(SLOW_CYC)) dut (
        .clk(clk), .rst(rst), .start(start), .x(x_i), .y(y_i),
        .busy(busy), .done(done), .product(product)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    function automatic int expect_lat(input logic [W-1:0] b);
        logic [2*N:0] ext;
        int t = 0;
        ext = {{(2*N-W){b[W-1]}}, b, 1'b0};
        for (int i = 0; i < N; i++) begin
            logic [2:0] tr;
            tr = ext[2*i +: 3];
            t += (tr == 3'b000 || tr == 3'b111) ? 1 : SLOW_CYC;
        end
        return t;
    endfunction

    // monitor: pops the scoreboard on every completion
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) lat++;
            if (done) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R7", "unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(product == e.prod, e.tag, "product", product, e.prod);
                    check(lat == e.lat, "R5", "busy cycles", lat, e.lat);
                    check(!busy, "R6", "busy with done", busy, 0);
                end
                lat = 0;
            end
        end
    end

    task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        exp_t e;
        logic [2*W-1:0] held;
        longint full;
        full   = longint'($signed(a)) * longint'($signed(b));
        e.prod = full[2*W-1:0];
        e.lat  = expect_lat(b);
        e.tag  = tag;
        sb.push_back(e);
        x_i = a; y_i = b; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R6", "busy after start", busy, 1);
        while (!done) @(negedge clk);
        held = product;
        @(negedge clk);
        check(done == 1'b0, "R6", "done width", done, 0);
        repeat (3) @(negedge clk);
        check(product == held, "R8", "product hold", product, held);
    endtask

    initial begin
        #(CLK_PER * 200000);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(busy == 1'b0, "R9", "reset busy", busy, 0);
        check(done == 1'b0, "R9", "reset done", done, 0);
        check(product == '0, "R9", "reset product", product, 0);

        // R3 / R5 minimum latency: all digits zero
        issue(16'sd1234, 16'd0, "R3");
        // R4: single nonzero digit at position 0
        issue(16'sd77, 16'hFFFF, "R4");
        // R5 alternating patterns, every data digit nonzero
        issue(16'sd300, 16'h5555, "R5");
        issue(-16'sd300, 16'hAAAA, "R5");
        // R2 recoding classes placed in known digits
        issue(16'sd91, 16'd1, "R2");
        issue(16'sd91, 16'd2, "R2");
        issue(16'sd91, 16'd3, "R2");
        issue(-16'sd91, 16'hFFFE, "R2");
        issue(16'sd91, 16'h0018, "R2");
        // R10 extremes
        issue(16'h8000, 16'h8000, "R10");
        issue(16'h8000, 16'h7FFF, "R10");
        issue(16'h7FFF, 16'h7FFF, "R10");
        issue(16'hFFFF, 16'h8000, "R10");
        issue(16'h7FFF, 16'hFFFF, "R10");

        // R7: start while busy with other operands
        begin
            exp_t e;
            longint full;
            full   = longint'(16'sd25) * longint'(-16'sd3);
            e.prod = full[2*W-1:0];
            e.lat  = expect_lat(16'hFFFD);
            e.tag  = "R7";
            sb.push_back(e);
            x_i = 16'sd25; y_i = 16'hFFFD; start = 1'b1;
            @(posedge clk); @(negedge clk);
            start = 1'b0;
            @(negedge clk);
            x_i = 16'h1111; y_i = 16'h5555; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            while (!done) @(negedge clk);
            repeat (40) @(negedge clk);
            check(sb.size() == 0, "R7", "pending results", sb.size(), 0);
            check(busy == 1'b0, "R7", "idle after ignored start", busy, 0);
        end

        // R1 random operands
        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] a, b;
            a = W'($urandom());
            b = W'($urandom());
            issue(a, b, "R1");
        end

        check(sb.size() == 0, "R1", "scoreboard drained", sb.size(), 0);
        finish_run();
    end
endmodule